// File: doc/BRIEF.md
# Memory-Attached Bitwise OR Engine

This block puts a small sequencer and a host on the two ports of a shared 256-word, 64-bit memory. The host loads two operands into fixed words and then writes any value to the top word. That write is stored like any other, and it also rings a doorbell that starts the sequencer. The sequencer fetches both operands, forms their bitwise OR, stores the result in a fixed word, and raises a done flag. The host then reads the result back through its own port.

The sequencer runs at a slower processing rate, by default one step every two host clocks. It is built as a strobe-enabled section of the host clock domain. The doorbell is one host cycle long, so it is held in a sticky flag that the slower sequencer is sure to see on its next step. A run happens once per reset: done stays high, and later doorbells have no effect until reset.

Top module: `or_engine_top`

## Requirements
- R1: While and after reset (active high, asynchronous), `eng_done` is 0 and the sequencer writes nothing to memory until a doorbell arrives.
- R2: A host write with `host_we`=1 stores `host_wdata` at `host_addr`. A host read presents `host_addr`, and `host_rdata` shows that word after the next rising clock edge (one cycle of latency).
- R3: A host write to address 255 (all address bits 1) starts the sequencer, and the written data is also stored at address 255.
- R4: Host writes to any address other than 255 do not start the sequencer: `eng_done` stays 0.
- R5: After a run, address 2 holds the bitwise OR of the words at address 0 (operand A) and address 1 (operand B), and addresses 0 and 1 keep their values.
- R6: The sequencer writes only address 2, once per run: other words, such as address 3, are left unchanged.
- R7: With the default processing rate (one step per two host clocks), `eng_done` rises no later than 14 host clock cycles after the doorbell write.
- R8: Once high, `eng_done` stays high until reset. A further doorbell does not start a new run, and the word at address 2 is not rewritten.
- R9: A reset during a run aborts it and clears the pending doorbell. Without a new doorbell, `eng_done` stays 0 and address 2 keeps its old value.
- R10: The sequencer changes state only on processing steps, and it drives its memory write enable only in the write state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; the processing steps are derived from it |
| rst | input | 1 | Asynchronous active-high reset |
| host_we | input | 1 | Host write enable |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, one cycle after the address |
| eng_done | output | 1 | Sticky flag set when the result has been stored |

## Verification
Two things happen in the same host cycle when the doorbell is written: the memory stores the data, and the decode latches the start request. The bench rings with a distinctive value, reads word 255 back, and checks that a run followed, so losing either path is caught. A second overlap is a doorbell arriving while a run is already complete. The bench rings again after done with different operands and checks that the result word still holds the first OR.

// File: rtl/or_eng_pkg.sv
package or_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ_A = 3'd1,
        ST_WAIT_A = 3'd2,
        ST_READ_B = 3'd3,
        ST_WAIT_B = 3'd4,
        ST_WRITE  = 3'd5,
        ST_DONE   = 3'd6
    } seq_state_e;

endpackage

// File: rtl/or_eng_tick.sv
module or_eng_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_full_rate
            assign tick = 1'b1;
        end else begin : g_divided
            typedef struct packed {
                logic [CNT_W-1:0] cnt;
            } tick_regs_t;

            tick_regs_t r_d, r_q;
            logic       wrap;

            always_comb begin
                wrap = (r_q.cnt == CNT_W'(DIV - 1));
                r_d  = r_q;
                if (wrap) r_d.cnt = '0;
                else      r_d.cnt = r_q.cnt + 1'b1;
            end

            always_ff @(posedge clk or posedge rst) begin
                if (rst) r_q <= '0;
                else     r_q <= r_d;
            end

            assign tick = wrap;

            assert_tick_gap_R10: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/or_eng_mem.sv
module or_eng_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] a_rdata_q;
    logic [DATA_W-1:0] b_rdata_q;

    // Both write ports share one process; the same-word collision is left undefined.
    always_ff @(posedge clk) begin
        if (a_we)
            mem_q[a_addr] <= a_wdata;
        if (b_en && b_we)
            mem_q[b_addr] <= b_wdata;
        a_rdata_q <= mem_q[a_addr];
        if (b_en)
            b_rdata_q <= mem_q[b_addr];
    end

    assign a_rdata = a_rdata_q;
    assign b_rdata = b_rdata_q;

endmodule

// File: rtl/or_eng_doorbell.sv
module or_eng_doorbell #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              req
);
    localparam logic [ADDR_W-1:0] BELL_ADDR = '1;

    typedef struct packed {
        logic req;
    } bell_regs_t;

    bell_regs_t r_d, r_q;
    logic       hit;

    always_comb begin
        hit   = host_we && (host_addr == BELL_ADDR);
        r_d   = r_q;
        r_d.req = r_q.req | hit;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign req = r_q.req;

    assert_bell_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == BELL_ADDR) |=> req);

    assert_bell_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        req |=> req);

endmodule

// File: rtl/or_eng_seq.sv
module or_eng_seq
    import or_eng_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 64,
    parameter int OPA_ADDR = 0,
    parameter int OPB_ADDR = 1,
    parameter int RES_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              req,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic [DATA_W-1:0] wdata,
    output logic              done
);
    localparam logic [ADDR_W-1:0] A_ADR = ADDR_W'(OPA_ADDR);
    localparam logic [ADDR_W-1:0] B_ADR = ADDR_W'(OPB_ADDR);
    localparam logic [ADDR_W-1:0] R_ADR = ADDR_W'(RES_ADDR);

    typedef struct packed {
        seq_state_e        st;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (tick) begin
            unique case (r_q.st)
                ST_IDLE:   if (req) r_d.st = ST_READ_A;
                ST_READ_A: r_d.st = ST_WAIT_A;
                ST_WAIT_A: begin
                    r_d.opa = rdata;
                    r_d.st  = ST_READ_B;
                end
                ST_READ_B: r_d.st = ST_WAIT_B;
                ST_WAIT_B: begin
                    r_d.opb = rdata;
                    r_d.st  = ST_WRITE;
                end
                ST_WRITE: begin
                    r_d.st   = ST_DONE;
                    r_d.done = 1'b1;
                end
                ST_DONE:   r_d.st = ST_DONE;
                default:   r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.st)
            ST_READ_B, ST_WAIT_B: addr = B_ADR;
            ST_WRITE:             addr = R_ADR;
            default:              addr = A_ADR;
        endcase
        we    = (r_q.st == ST_WRITE);
        wdata = r_q.opa | r_q.opb;
    end

    assign done = r_q.done;

    assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(r_q.st));

    assert_single_write_R6: assert property (@(posedge clk) disable iff (rst)
        (we && tick) |=> !we);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_no_rerun_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (r_q.st == ST_DONE) && !we);

    assert_idle_without_req_R4: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && !req) |=> (r_q.st == ST_IDLE));

endmodule

// File: rtl/or_engine_top.sv
module or_engine_top #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 64,
    parameter int CLK_DIV  = 2,
    parameter int OPA_ADDR = 0,
    parameter int OPB_ADDR = 1,
    parameter int RES_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              eng_done
);
    logic              step;
    logic              bell_req;
    logic [ADDR_W-1:0] e_addr;
    logic              e_we;
    logic [DATA_W-1:0] e_wdata;
    logic [DATA_W-1:0] e_rdata;

    or_eng_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (step)
    );

    or_eng_doorbell #(.ADDR_W(ADDR_W)) u_bell (
        .clk       (clk),
        .rst       (rst),
        .host_we   (host_we),
        .host_addr (host_addr),
        .req       (bell_req)
    );

    or_eng_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .a_we    (host_we),
        .a_addr  (host_addr),
        .a_wdata (host_wdata),
        .a_rdata (host_rdata),
        .b_en    (step),
        .b_we    (e_we),
        .b_addr  (e_addr),
        .b_wdata (e_wdata),
        .b_rdata (e_rdata)
    );

    or_eng_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .OPA_ADDR (OPA_ADDR),
        .OPB_ADDR (OPB_ADDR),
        .RES_ADDR (RES_ADDR)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .tick  (step),
        .req   (bell_req),
        .rdata (e_rdata),
        .addr  (e_addr),
        .we    (e_we),
        .wdata (e_wdata),
        .done  (eng_done)
    );

    assert_write_target_R6: assert property (@(posedge clk) disable iff (rst)
        e_we |-> (e_addr == ADDR_W'(RES_ADDR)));

    assert_done_needs_bell_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_done) |-> bell_req);

endmodule

// File: tb/or_engine_top_tb.sv
module or_engine_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        eng_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    or_engine_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_done   (eng_done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        host_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [63:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [63:0] d);
        host_addr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!eng_done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_or(input string req, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] v;
        int cyc;
        do_reset();
        hwrite(8'd0, a);
        hwrite(8'd1, b);
        hwrite(8'd3, 64'h3333_c0de_3333_c0de);
        hwrite(8'hff, 64'hbe11_0000_0000_0001);
        wait_done(cyc);
        check({req, " done rises"}, 64'(eng_done), 64'd1);
        check("R7 done latency bound", 64'(cyc <= 14), 64'd1);
        hread(8'd2, v); check({req, " result word"}, v, a | b);
        hread(8'd0, v); check("R5 operand A kept", v, a);
        hread(8'd1, v); check("R5 operand B kept", v, b);
        hread(8'd3, v); check("R6 neighbour word untouched", v, 64'h3333_c0de_3333_c0de);
    endtask

    task automatic t_reset_state();
        logic [63:0] v;
        do_reset();
        check("R1 done low after reset", 64'(eng_done), 64'd0);
        hwrite(8'd2, 64'h5a5a_5a5a_5a5a_5a5a);
        repeat (20) @(negedge clk);
        hread(8'd2, v);
        check("R1 no engine write without doorbell", v, 64'h5a5a_5a5a_5a5a_5a5a);
        check("R1 done still low", 64'(eng_done), 64'd0);
    endtask

    task automatic t_host_rw();
        logic [63:0] v;
        do_reset();
        hwrite(8'd17, 64'h0123_4567_89ab_cdef);
        hwrite(8'd254, 64'hfedc_ba98_7654_3210);
        hread(8'd17, v);  check("R2 host read word 17", v, 64'h0123_4567_89ab_cdef);
        hread(8'd254, v); check("R2 host read word 254", v, 64'hfedc_ba98_7654_3210);
    endtask

    task automatic t_non_bell();
        do_reset();
        for (int i = 0; i < 8; i++) hwrite(8'(i * 31 + 4), 64'(i));
        hwrite(8'd254, '1);
        hwrite(8'd127, '1);
        repeat (30) @(negedge clk);
        check("R4 no start from other addresses", 64'(eng_done), 64'd0);
    endtask

    task automatic t_bell_store();
        logic [63:0] v;
        int cyc;
        do_reset();
        hwrite(8'd0, 64'h1); hwrite(8'd1, 64'h2);
        hwrite(8'hff, 64'hd00d_feed_cafe_0255);
        hread(8'hff, v);
        check("R3 doorbell data stored", v, 64'hd00d_feed_cafe_0255);
        wait_done(cyc);
        check("R3 doorbell started run", 64'(eng_done), 64'd1);
        hread(8'd2, v); check("R3 result after doorbell", v, 64'h3);
    endtask

    task automatic t_no_rerun();
        logic [63:0] v;
        run_or("R5", 64'h00f0_00f0_0000_1111, 64'h0f00_0f00_1000_0000);
        hwrite(8'd0, 64'hffff_0000_0000_0000);
        hwrite(8'd1, 64'h0000_0000_0000_ffff);
        hwrite(8'hff, 64'h2);
        repeat (30) @(negedge clk);
        check("R8 done held", 64'(eng_done), 64'd1);
        hread(8'd2, v);
        check("R8 second doorbell ignored", v, 64'h0ff0_0ff0_1000_1111);
    endtask

    task automatic t_reset_mid_run();
        logic [63:0] v;
        do_reset();
        hwrite(8'd0, 64'hf); hwrite(8'd1, 64'hf0);
        hwrite(8'd2, 64'h7777_7777_7777_7777);
        hwrite(8'hff, 64'h0);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (30) @(negedge clk);
        check("R9 done low after abort", 64'(eng_done), 64'd0);
        hread(8'd2, v);
        check("R9 result word not written", v, 64'h7777_7777_7777_7777);
    endtask

    initial begin
        t_reset_state();
        t_host_rw();
        t_non_bell();
        t_bell_store();
        run_or("R5", 64'hffff_ffff_0000_0000, 64'h0000_0000_ffff_ffff);
        run_or("R5", 64'h0, 64'h0);
        run_or("R6", 64'haaaa_aaaa_aaaa_aaaa, 64'h5555_5555_5555_5555);
        run_or("R10", 64'h8000_0000_0000_0001, 64'h8123_0000_4500_0000);
        t_no_rerun();
        t_reset_mid_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule